// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small, fully associative translation cache. It sits between a core's address generator and the memory system. A lookup presents a virtual address together with the identifier of the running address space. Every stored entry holds a virtual page number, a physical frame number and an address-space tag. All entries are compared at once. When one of them matches both the page number and the tag, the physical address appears in the same cycle: the stored frame number with the untouched page offset appended below it.

When a lookup finds no match, the block raises a request to an external page-table walker. The walker reads the page table in main memory. The request carries the missing page number and tag, and the block stops taking new lookups until the walker accepts that request. The walker later writes the translation back through the refill port. A refill first goes to a free slot. If every slot is in use, it replaces a victim chosen in rotation.

Software can drop every translation at once, or drop only the translations that belong to one address space. Because entries carry a tag, translations from different processes can live side by side, and a context switch needs no flush.

Top module: `asid_tlb`

## Requirements
- R1: After reset no entry is valid, `lk_ready` is 1, `walk_valid` is 0, and every lookup misses.
- R2: A lookup accepted (`lk_valid` and `lk_ready` both 1) that matches a valid entry drives `lk_hit`=1 in the same cycle. `lk_paddr` is then {stored frame number, `lk_vaddr[OFF_W-1:0]`}, and no walk request follows.
- R3: A hit requires the entry's tag to equal `lk_asid`. The same page number stored under another tag misses, and on a miss `lk_paddr` is 0.
- R4: An accepted lookup that misses raises `walk_valid` on the next cycle, carrying that page number and tag. `walk_valid`, `walk_vpn` and `walk_asid` hold steady until a cycle with `walk_ready`=1. While `walk_valid` is 1, `lk_ready` is 0 and `lk_hit` is 0.
- R5: A refill becomes visible to lookups from the cycle after `fill_valid`. A lookup in the same cycle as the refill sees the old contents.
- R6: A refill is written to the lowest-index slot that is not valid once the same cycle's invalidation has been applied.
- R7: When all slots are valid, a refill replaces the slot named by a rotating pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, only on such a replacement.
- R8: `flush_all` invalidates every entry at the next edge. A refill in the same cycle is dropped.
- R9: `flush_asid_en` invalidates, at the next edge, every entry whose tag equals `flush_asid`, and only those. A refill in the same cycle carrying that tag is dropped; a refill with any other tag is kept.
- R10: A lookup in the same cycle as an invalidation still sees the entries as they were before it.
- R11: If several valid entries match one lookup, the lowest-index match supplies the frame number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup accepted this cycle (low while a walk request is pending) |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address: page number above the offset |
| lk_asid | input | ASID_W | Tag of the current address space |
| lk_hit | output | 1 | Accepted lookup found a translation |
| lk_paddr | output | PFN_W+OFF_W | Frame number above the offset; 0 when there is no hit |
| walk_valid | output | 1 | Walk request pending |
| walk_ready | input | 1 | Walker accepts the pending request |
| walk_vpn | output | VPN_W | Page number to walk |
| walk_asid | output | ASID_W | Tag of the walk |
| fill_valid | input | 1 | Refill present; always accepted |
| fill_vpn | input | VPN_W | Refill page number |
| fill_pfn | input | PFN_W | Refill frame number |
| fill_asid | input | ASID_W | Refill tag |
| flush_all | input | 1 | Invalidate every entry |
| flush_asid_en | input | 1 | Invalidate the entries of one tag |
| flush_asid | input | ASID_W | Tag to invalidate |

## Verification
The collision most likely to go wrong is a refill landing in the same cycle as a tag-selective invalidation, with a lookup in flight as well. The bench provokes it twice. In the first cycle, the refill's tag equals the invalidated tag, so the refill must vanish while the concurrent lookup of a doomed entry still hits. In the second, the refill's tag differs, so it must land in the lowest slot freed by that same invalidation. A reference table in the bench applies the invalidation first, then the drop rule, then the free-slot or rotation rule. Sweeps of every stored page against every tag after each event judge the outcome: hits, misses and frame numbers must all agree with that table.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int TLB_ENTRIES_DEF = 8;
  localparam int TLB_VPN_W_DEF   = 20;
  localparam int TLB_PFN_W_DEF   = 20;
  localparam int TLB_ASID_W_DEF  = 8;
  localparam int TLB_OFF_W_DEF   = 12;

  typedef enum logic [1:0] {
    FILL_NONE  = 2'd0,
    FILL_FREE  = 2'd1,
    FILL_EVICT = 2'd2
  } fill_kind_e;
endpackage

// File: rtl/tlb_first_one.sv
module tlb_first_one #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx   = i[IW-1:0];
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8,
  parameter int IW     = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [ASID_W-1:0] q_asid,
  output logic [N-1:0]      match_vec,
  input  logic [IW-1:0]     rd_idx,
  output logic [PFN_W-1:0]  rd_pfn,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid,
  output logic [N-1:0]      live_vec
);
  logic [N-1:0]      valid_q;
  logic [N-1:0]      kill_vec;
  logic [VPN_W-1:0]  vpn_q  [N];
  logic [PFN_W-1:0]  pfn_q  [N];
  logic [ASID_W-1:0] asid_q [N];

  assign live_vec = valid_q & ~kill_vec;
  assign rd_pfn   = pfn_q[rd_idx];

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic hit_me;
    assign hit_me       = wr_en && (wr_idx == IW'(g));
    assign match_vec[g] = valid_q[g] && (vpn_q[g] == q_vpn) && (asid_q[g] == q_asid);
    assign kill_vec[g]  = valid_q[g] &&
                          (flush_all || (flush_asid_en && (asid_q[g] == flush_asid)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
      end else if (hit_me) begin
        valid_q[g] <= 1'b1;
      end else if (kill_vec[g]) begin
        valid_q[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_me) begin
        vpn_q[g]  <= wr_vpn;
        pfn_q[g]  <= wr_pfn;
        asid_q[g] <= wr_asid;
      end
    end

    AST_TAG_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_asid_en && valid_q[g] && (asid_q[g] == flush_asid) && !hit_me) |=> !valid_q[g]); // R9
  end

  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0)); // R8
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_req,
  input  logic [N-1:0]  live_vec,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx
);
  logic [IW-1:0] rr_q;
  logic [IW-1:0] free_idx;
  logic          has_free;
  fill_kind_e    kind;

  tlb_first_one #(.N(N), .IW(IW)) u_free (
    .req   (~live_vec),
    .idx   (free_idx),
    .found (has_free)
  );

  always_comb begin
    if (!fill_req)     kind = FILL_NONE;
    else if (has_free) kind = FILL_FREE;
    else               kind = FILL_EVICT;
  end

  assign wr_en  = (kind != FILL_NONE);
  assign wr_idx = (kind == FILL_FREE) ? free_idx : rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (kind == FILL_EVICT) begin
      rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  AST_FREE_SLOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == FILL_FREE) |-> !live_vec[wr_idx]); // R6
  AST_EVICT_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == FILL_EVICT) |-> (&live_vec)); // R7
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = TLB_ENTRIES_DEF,
  parameter int VPN_W   = TLB_VPN_W_DEF,
  parameter int PFN_W   = TLB_PFN_W_DEF,
  parameter int ASID_W  = TLB_ASID_W_DEF,
  parameter int OFF_W   = TLB_OFF_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lk_valid,
  output logic                    lk_ready,
  input  logic [VPN_W+OFF_W-1:0]  lk_vaddr,
  input  logic [ASID_W-1:0]       lk_asid,
  output logic                    lk_hit,
  output logic [PFN_W+OFF_W-1:0]  lk_paddr,
  output logic                    walk_valid,
  input  logic                    walk_ready,
  output logic [VPN_W-1:0]        walk_vpn,
  output logic [ASID_W-1:0]       walk_asid,
  input  logic                    fill_valid,
  input  logic [VPN_W-1:0]        fill_vpn,
  input  logic [PFN_W-1:0]        fill_pfn,
  input  logic [ASID_W-1:0]       fill_asid,
  input  logic                    flush_all,
  input  logic                    flush_asid_en,
  input  logic [ASID_W-1:0]       flush_asid
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0]   lk_vpn;
  logic [OFF_W-1:0]   lk_off;
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] live_vec;
  logic [IW-1:0]      hit_idx;
  logic               any_match;
  logic [PFN_W-1:0]   hit_pfn;
  logic               lk_fire;
  logic               fill_drop;
  logic               fill_req;
  logic               wr_en;
  logic [IW-1:0]      wr_idx;

  assign lk_vpn = lk_vaddr[VPN_W+OFF_W-1:OFF_W];
  assign lk_off = lk_vaddr[OFF_W-1:0];

  tlb_store #(
    .N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .IW(IW)
  ) u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .q_vpn         (lk_vpn),
    .q_asid        (lk_asid),
    .match_vec     (match_vec),
    .rd_idx        (hit_idx),
    .rd_pfn        (hit_pfn),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .wr_vpn        (fill_vpn),
    .wr_pfn        (fill_pfn),
    .wr_asid       (fill_asid),
    .flush_all     (flush_all),
    .flush_asid_en (flush_asid_en),
    .flush_asid    (flush_asid),
    .live_vec      (live_vec)
  );

  tlb_first_one #(.N(ENTRIES), .IW(IW)) u_hit_sel (
    .req   (match_vec),
    .idx   (hit_idx),
    .found (any_match)
  );

  assign fill_drop = flush_all || (flush_asid_en && (fill_asid == flush_asid));
  assign fill_req  = fill_valid && !fill_drop;

  tlb_victim #(.N(ENTRIES), .IW(IW)) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill_req (fill_req),
    .live_vec (live_vec),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx)
  );

  assign lk_ready = !walk_valid;
  assign lk_fire  = lk_valid && lk_ready;
  assign lk_hit   = lk_fire && any_match;
  assign lk_paddr = lk_hit ? {hit_pfn, lk_off} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walk_valid <= 1'b0;
      walk_vpn   <= '0;
      walk_asid  <= '0;
    end else if (walk_valid) begin
      if (walk_ready) walk_valid <= 1'b0;
    end else if (lk_fire && !any_match) begin
      walk_valid <= 1'b1;
      walk_vpn   <= lk_vpn;
      walk_asid  <= lk_asid;
    end
  end

  AST_MISS_REQUESTS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && !lk_hit) |=> (walk_valid && (walk_vpn == $past(lk_vpn)))); // R4
  AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_valid && !walk_ready) |=> (walk_valid && $stable(walk_vpn) && $stable(walk_asid))); // R4
  AST_NO_HIT_WHILE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    walk_valid |-> !lk_hit); // R4
  AST_HIT_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |=> !walk_valid); // R2
  AST_MISS_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == '0)); // R3
endmodule

// File: tb/asid_tlb_test.sv
`timescale 1ns/1ps
module asid_tlb_test;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_hit;
  logic [31:0] lk_paddr;
  logic        walk_valid;
  logic        walk_ready = 1'b1;
  logic [19:0] walk_vpn;
  logic [7:0]  walk_asid;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic [7:0]  fill_asid = '0;
  logic        flush_all = 1'b0;
  logic        flush_asid_en = 1'b0;
  logic [7:0]  flush_asid = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  asid_tlb uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .walk_valid(walk_valid), .walk_ready(walk_ready), .walk_vpn(walk_vpn), .walk_asid(walk_asid),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_asid(fill_asid),
    .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
  );

  // reference table built from the requirements
  logic [19:0] m_vpn  [N];
  logic [19:0] m_pfn  [N];
  logic [7:0]  m_asid [N];
  bit          m_v    [N];
  int          m_rr = 0;
  bit          e_wv = 1'b0;
  logic [19:0] e_wvpn = '0;
  logic [7:0]  e_wasid = '0;

  function automatic logic [19:0] vpn_of(input int i);
    return 20'h01000 + 20'(i * 291);
  endfunction
  function automatic logic [19:0] pfn_of(input int i);
    return 20'hA0000 + 20'(i * 37);
  endfunction

  function automatic int m_find(input logic [19:0] v, input logic [7:0] a);
    for (int k = 0; k < N; k++)
      if (m_v[k] && m_vpn[k] == v && m_asid[k] == a) return k; // R11 lowest index
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_commit();
    bit drop;
    int slot;
    if (flush_all) for (int k = 0; k < N; k++) m_v[k] = 1'b0;
    if (flush_asid_en)
      for (int k = 0; k < N; k++) if (m_asid[k] == flush_asid) m_v[k] = 1'b0;
    drop = flush_all || (flush_asid_en && fill_asid == flush_asid);
    if (fill_valid && !drop) begin
      slot = -1;
      for (int k = N - 1; k >= 0; k--) if (!m_v[k]) slot = k;
      if (slot < 0) begin
        slot = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      m_v[slot] = 1'b1; m_vpn[slot] = fill_vpn; m_pfn[slot] = fill_pfn; m_asid[slot] = fill_asid;
    end
  endtask

  task automatic cyc(input string tag);
    int  hi;
    bit  eh;
    #1;
    chk(lk_ready == !e_wv, "R4", "lk_ready", lk_ready, !e_wv);
    chk(walk_valid == e_wv, "R4", "walk_valid", walk_valid, e_wv);
    if (e_wv) begin
      chk(walk_vpn == e_wvpn, "R4", "walk_vpn", walk_vpn, e_wvpn);
      chk(walk_asid == e_wasid, "R4", "walk_asid", walk_asid, e_wasid);
    end
    hi = m_find(lk_vaddr[31:12], lk_asid);
    eh = lk_valid && !e_wv && (hi >= 0);
    chk(lk_hit == eh, tag, "lk_hit", lk_hit, eh);
    if (eh) chk(lk_paddr == {m_pfn[hi], lk_vaddr[11:0]}, tag, "lk_paddr",
                lk_paddr, {m_pfn[hi], lk_vaddr[11:0]});
    else    chk(lk_paddr == '0, "R3", "lk_paddr on miss", lk_paddr, 0);
    @(posedge clk);
    if (e_wv) begin
      if (walk_ready) e_wv = 1'b0;
    end else if (lk_valid && !eh) begin
      e_wv = 1'b1; e_wvpn = lk_vaddr[31:12]; e_wasid = lk_asid;
    end
    model_commit();
    #1;
  endtask

  task automatic idle();
    lk_valid = 0; fill_valid = 0; flush_all = 0; flush_asid_en = 0; walk_ready = 1;
  endtask

  task automatic look(input logic [19:0] v, input logic [7:0] a, input logic [11:0] off);
    lk_valid = 1; lk_vaddr = {v, off}; lk_asid = a;
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic [7:0] a);
    fill_valid = 1; fill_vpn = v; fill_pfn = p; fill_asid = a;
  endtask

  // every known page against every tag, each lookup followed by a drain cycle
  task automatic sweep(input string tag, input int upto);
    for (int i = 0; i < upto; i++)
      for (int a = 0; a < 3; a++) begin
        idle(); look(vpn_of(i), 8'(a), 12'((i * 97 + a * 613) & 12'hfff));
        cyc(tag);
        idle(); cyc(tag);
      end
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin
      m_v[k] = 0; m_vpn[k] = '0; m_pfn[k] = '0; m_asid[k] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset state, first lookup misses
    idle(); look(vpn_of(0), 8'd0, 12'h123); cyc("R1");
    idle(); cyc("R1");

    // R4: walk request held under back-pressure, lookups stalled
    walk_ready = 0; look(vpn_of(3), 8'd5, 12'h010); cyc("R4");
    look(vpn_of(4), 8'd6, 12'h020); cyc("R4");
    cyc("R4"); cyc("R4");
    walk_ready = 1; cyc("R4");
    idle(); cyc("R4");

    // R5 + R6: fill eight slots; lookup of the page during its own fill misses
    for (int i = 0; i < N; i++) begin
      idle(); fill(vpn_of(i), pfn_of(i), 8'(i % 3)); look(vpn_of(i), 8'(i % 3), 12'h0ff);
      cyc("R5");
      idle(); look(vpn_of(i), 8'(i % 3), 12'h0ff); cyc("R5");
      idle(); cyc("R5");
    end

    // R2 + R3: full sweep of pages and tags
    sweep("R2", N);

    // R7: three replacements in rotation
    for (int i = N; i < N + 3; i++) begin
      idle(); fill(vpn_of(i), pfn_of(i), 8'(i % 3)); cyc("R7");
    end
    idle(); sweep("R7", N + 3);

    // R9 + R10: tag flush with concurrent lookup and a same-tag refill (dropped)
    idle(); flush_asid_en = 1; flush_asid = 8'd1;
    look(vpn_of(4), 8'd1, 12'h444);
    fill(20'h77777, 20'h12345, 8'd1);
    cyc("R10");
    idle(); look(20'h77777, 8'd1, 12'h001); cyc("R9");
    idle(); sweep("R9", N + 3);

    // R9 + R6: tag flush with an other-tag refill landing in a freed slot
    idle(); flush_asid_en = 1; flush_asid = 8'd2;
    fill(vpn_of(20), pfn_of(20), 8'd0);
    cyc("R9");
    idle(); sweep("R6", N + 3);
    idle(); look(vpn_of(20), 8'd0, 12'habc); cyc("R6");
    idle(); cyc("R6");
    for (int i = 21; i < 30; i++) begin
      idle(); fill(vpn_of(i), pfn_of(i), 8'(i % 3)); cyc("R7");
    end
    idle(); sweep("R7", 30);

    // R11: duplicate match, lowest index wins
    idle(); flush_all = 1; cyc("R8");
    idle(); fill(20'h0ABCD, 20'h11111, 8'd9); cyc("R11");
    idle(); fill(20'h0ABCD, 20'h22222, 8'd9); cyc("R11");
    idle(); look(20'h0ABCD, 8'd9, 12'h777); cyc("R11");
    idle(); cyc("R11");

    // R8: flush-all drops a concurrent refill and empties the table
    for (int i = 0; i < 4; i++) begin
      idle(); fill(vpn_of(i), pfn_of(i), 8'(i % 3)); cyc("R8");
    end
    idle(); flush_all = 1; fill(vpn_of(40), pfn_of(40), 8'd0);
    look(vpn_of(1), 8'd1, 12'h321); cyc("R10");
    idle(); look(vpn_of(40), 8'd0, 12'h000); cyc("R8");
    idle(); sweep("R8", 4);

    idle(); cyc("R1");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule